// File: doc/BRIEF.md
# Three-Channel Phase-Angle Firing Controller

This block times the gate triggers of three AC phases. Each phase has a zero-crossing input that idles high and falls once per half-cycle. The falling edge starts that channel's timing. When the shared firing delay has elapsed, the channel drives its gate output high for a fixed pulse width. It then stays quiet until its next crossing. A later delay gives less power to the load.

The firing delay comes from a setpoint word that arrives with a valid strobe. The value is converted as delay = (2^SP_W − 1 − setpoint) × SCALE microseconds and capped at MAX_DELAY_US. A refresh timer limits how often a new delay is taken. All timing runs on a microsecond tick divided down from the system clock. Each channel is a four-state machine:

- CH_IDLE: unarmed, the state after reset.
- CH_WAIT: armed and timing the delay.
- CH_FIRE: gate high.
- CH_DONE: fired, waiting for the next crossing.

The transitions are:

- arm: CH_IDLE→CH_WAIT on a crossing.
- restart: CH_WAIT→CH_WAIT on a crossing, which zeroes the elapsed count.
- trigger: CH_WAIT→CH_FIRE once elapsed ≥ delay.
- hold: CH_FIRE→CH_FIRE on a crossing, which marks a re-arm.
- finish: CH_FIRE→CH_DONE at the end of the pulse with no re-arm.
- rearm: CH_FIRE→CH_WAIT at the end of the pulse with a re-arm pending.
- next: CH_DONE→CH_WAIT on a crossing.

Top module: `tri_phase_fire`

## Requirements
- R1: A zero crossing is the falling edge of a channel's zc_n bit after a two-flop synchronizer. A rising edge, or a level held low, starts nothing.
- R2: After reset every gate bit is 0 and no channel is armed, so no gate pulse appears until a crossing arrives.
- R3: An armed channel raises its gate once the microseconds elapsed since its crossing reach the delay in use. The tolerance is ±1 µs plus the synchronizer latency.
- R4: A gate pulse lasts PULSE_US microseconds, give or take one tick.
- R5: A channel gives exactly one pulse per crossing. Its saturating elapsed counter never wraps to zero, so no further pulse appears without a new crossing, however long the wait.
- R6: An accepted setpoint s sets the delay to (2^SP_W − 1 − s) × SCALE µs. Setpoint all-ones gives a delay of 0.
- R7: A computed delay above MAX_DELAY_US is replaced by MAX_DELAY_US.
- R8: The delay after reset is MAX_DELAY_US. A sp_valid strobe is accepted only when REFRESH_US µs have passed since the last accepted one; the first strobe after reset is always accepted. Any other strobe leaves the delay unchanged.
- R9: A crossing during the delay restarts the timing from that crossing.
- R10: A crossing during a gate pulse leaves the pulse at full length. It re-arms the channel, and the next pulse is timed from that crossing.
- R11: The three channels time independently, and all use the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_PER_US cycles per microsecond |
| rst_n | input | 1 | Asynchronous reset, active low |
| zc_n | input | NCH | Zero-crossing inputs, idle high, falling edge = crossing |
| setpoint | input | SP_W | Power setpoint, higher value = earlier firing |
| sp_valid | input | 1 | One-cycle strobe qualifying setpoint |
| gate | output | NCH | Gate trigger outputs, active high |

## Verification
The bench builds the block with the parameters below. Each choice shrinks a window so that its boundary can be reached in a few thousand cycles.

| Parameter | Bench value | Effect |
|---|---|---|
| CLK_PER_US | 4 | A microsecond lasts four cycles |
| PULSE_US | 20 | Short gate pulse |
| REFRESH_US | 400 | Both sides of the refresh window can be tested |
| SP_W | 4 | 4-bit setpoint |
| SCALE | 10 | Computed delays from 0 to 150 µs |
| MAX_DELAY_US | 95 | Setpoint 0 lands well above the cap of 95 µs |

With these values, the clamp, the zero delay, a strobe ignored inside the refresh window and crossings that fall inside a pulse are all short directed cases.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_FIRE = 2'd2,
        CH_DONE = 2'd3
    } chan_state_e;
endpackage

// File: rtl/pf_edge_sync.sv
module pf_edge_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] zc_n,
    output logic [N-1:0] zc_fall
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= zc_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign zc_fall = prev_q & ~sync_q;
endmodule

// File: rtl/pf_us_tick.sv
module pf_us_tick #(
    parameter int CLK_PER_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
    localparam logic [W-1:0] LAST = W'(CLK_PER_US - 1);

    logic [W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + W'(1);
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/pf_angle_reg.sv
module pf_angle_reg #(
    parameter int SP_W         = 10,
    parameter int SCALE        = 10,
    parameter int MAX_DELAY_US = 9500,
    parameter int REFRESH_US   = 100000,
    parameter int DLY_W        = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SP_W-1:0]  setpoint,
    input  logic             sp_valid,
    output logic [DLY_W-1:0] delay_us
);
    localparam int REF_W = $clog2(REFRESH_US + 1);
    localparam logic [REF_W-1:0] REF_END = REF_W'(REFRESH_US);
    localparam logic [31:0] SP_TOP = 32'((1 << SP_W) - 1);

    logic [REF_W-1:0] ref_q;
    logic             due;
    logic             take;
    logic [31:0]      raw;
    logic [31:0]      capped;

    assign due  = (ref_q == REF_END);
    assign take = due && sp_valid;

    always_comb begin
        raw    = (SP_TOP - 32'(setpoint)) * 32'(SCALE);
        capped = (raw > 32'(MAX_DELAY_US)) ? 32'(MAX_DELAY_US) : raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q    <= REF_END;
            delay_us <= DLY_W'(MAX_DELAY_US);
        end else if (take) begin
            ref_q    <= '0;
            delay_us <= DLY_W'(capped);
        end else if (tick && !due) begin
            ref_q    <= ref_q + REF_W'(1);
        end
    end

    // R7
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (delay_us <= DLY_W'(MAX_DELAY_US)));

    // R8
    refresh_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(delay_us) |-> $past(due && sp_valid));
endmodule

// File: rtl/pf_channel.sv
module pf_channel
    import pf_pkg::*;
#(
    parameter int DLY_W    = 14,
    parameter int PULSE_US = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             zc_fall,
    input  logic [DLY_W-1:0] delay_us,
    output logic             gate
);
    localparam int EW = DLY_W + 1;
    localparam int PW = $clog2(PULSE_US + 1);
    localparam logic [PW-1:0] P_LAST = PW'(PULSE_US - 1);

    chan_state_e  state, next;
    logic [EW-1:0] elapsed;
    logic [PW-1:0] pulse_cnt;
    logic          rearm;
    logic          pulse_end;
    logic          reached;

    assign reached   = (elapsed >= {1'b0, delay_us});
    assign pulse_end = (state == CH_FIRE) && tick && (pulse_cnt == P_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= next;
    end

    always_comb begin
        next = state;
        unique case (state)
            CH_IDLE: if (zc_fall) next = CH_WAIT;
            CH_WAIT: if (!zc_fall && reached) next = CH_FIRE;
            CH_FIRE: if (pulse_end) next = (rearm || zc_fall) ? CH_WAIT : CH_DONE;
            CH_DONE: if (zc_fall) next = CH_WAIT;
            default: next = CH_IDLE;
        endcase
    end

    // output process
    always_comb begin
        gate = 1'b0;
        unique case (state)
            CH_FIRE: gate = 1'b1;
            default: gate = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed   <= '0;
            pulse_cnt <= '0;
            rearm     <= 1'b0;
        end else begin
            if (zc_fall)
                elapsed <= '0;
            else if (tick && (elapsed != '1))
                elapsed <= elapsed + EW'(1);

            if (state != CH_FIRE)
                pulse_cnt <= '0;
            else if (tick)
                pulse_cnt <= pulse_cnt + PW'(1);

            if (state != CH_FIRE || pulse_end)
                rearm <= 1'b0;
            else if (zc_fall)
                rearm <= 1'b1;
        end
    end

    // R3
    fire_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_FIRE && $past(state) == CH_WAIT) |-> $past(reached));

    // R4
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate) |-> $past(pulse_cnt == P_LAST));

    // R5
    no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_DONE && !zc_fall) |=> (state == CH_DONE));

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed == '0 && $past(elapsed) != '0) |-> $past(zc_fall));

    // R10
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_FIRE && zc_fall && !pulse_end) |=> (state == CH_FIRE));
endmodule

// File: rtl/tri_phase_fire.sv
module tri_phase_fire #(
    parameter int NCH          = 3,
    parameter int CLK_PER_US   = 250,
    parameter int PULSE_US     = 200,
    parameter int REFRESH_US   = 100000,
    parameter int SP_W         = 10,
    parameter int SCALE        = 10,
    parameter int MAX_DELAY_US = 9500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  zc_n,
    input  logic [SP_W-1:0] setpoint,
    input  logic            sp_valid,
    output logic [NCH-1:0]  gate
);
    localparam int DLY_W = $clog2(MAX_DELAY_US + 1);

    logic             tick;
    logic [NCH-1:0]   zc_fall;
    logic [DLY_W-1:0] delay_us;

    pf_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    pf_edge_sync #(.N(NCH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .zc_n    (zc_n),
        .zc_fall (zc_fall)
    );

    pf_angle_reg #(
        .SP_W         (SP_W),
        .SCALE        (SCALE),
        .MAX_DELAY_US (MAX_DELAY_US),
        .REFRESH_US   (REFRESH_US),
        .DLY_W        (DLY_W)
    ) u_angle (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .setpoint (setpoint),
        .sp_valid (sp_valid),
        .delay_us (delay_us)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pf_channel #(
            .DLY_W    (DLY_W),
            .PULSE_US (PULSE_US)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .zc_fall  (zc_fall[c]),
            .delay_us (delay_us),
            .gate     (gate[c])
        );
    end

    // R1
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_fall != '0) |-> $past(zc_n != '1, 2));
endmodule

// File: tb/tri_phase_fire_test.sv
`timescale 1ns/1ps
module tri_phase_fire_test;
    localparam int CPU = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] zc_n = 3'b111;
    logic [3:0] setpoint = '0;
    logic       sp_valid = 1'b0;
    logic [2:0] gate;

    int total = 0;
    int bad = 0;
    longint cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tri_phase_fire #(
        .NCH(3), .CLK_PER_US(CPU), .PULSE_US(20), .REFRESH_US(400),
        .SP_W(4), .SCALE(10), .MAX_DELAY_US(95)
    ) uut (
        .clk(clk), .rst_n(rst_n), .zc_n(zc_n),
        .setpoint(setpoint), .sp_valid(sp_valid), .gate(gate)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: gate=%b expected=%b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic at_us(input longint t0, input int us);
        while (cyc < t0 + longint'(us * CPU)) @(negedge clk);
    endtask

    task automatic zc_hit(input int ch, output longint t0);
        t0 = cyc;
        zc_n[ch] = 1'b0;
        @(negedge clk);
        zc_n[ch] = 1'b1;
    endtask

    task automatic send_sp(input logic [3:0] v);
        setpoint = v;
        sp_valid = 1'b1;
        @(negedge clk);
        sp_valid = 1'b0;
    endtask

    task automatic quiet(input string req, input longint t0, input int from_us, input int to_us);
        logic [2:0] seen;
        seen = '0;
        at_us(t0, from_us);
        while (cyc < t0 + longint'(to_us * CPU)) begin
            seen = seen | gate;
            @(negedge clk);
        end
        chk(req, seen, 3'b000);
    endtask

    task automatic t_reset();
        longint t0;
        repeat (5) @(negedge clk);
        chk("R2 reset", gate, 3'b000);
        rst_n = 1'b1;
        t0 = cyc;
        quiet("R2 unarmed", t0, 0, 150);
    endtask

    task automatic t_default();
        longint t0;
        zc_hit(0, t0);
        at_us(t0, 92);  chk("R8 initial delay early", gate, 3'b000);
        at_us(t0, 98);  chk("R3 fire at delay", gate, 3'b001);
        at_us(t0, 112); chk("R4 pulse held", gate, 3'b001);
        at_us(t0, 118); chk("R4 pulse ended", gate, 3'b000);
        quiet("R5 single pulse", t0, 118, 420);
    endtask

    task automatic t_scale();
        longint t0;
        send_sp(4'd10);
        zc_hit(1, t0);
        at_us(t0, 47); chk("R6 delay 50 early", gate, 3'b000);
        at_us(t0, 53); chk("R6 delay 50 fire", gate, 3'b010);
        at_us(t0, 80);
        send_sp(4'd15);
        zc_hit(2, t0);
        at_us(t0, 47); chk("R8 strobe ignored early", gate, 3'b000);
        at_us(t0, 53); chk("R8 strobe ignored fire", gate, 3'b100);
        at_us(t0, 420);
        send_sp(4'd15);
        zc_hit(0, t0);
        at_us(t0, 3);  chk("R6 zero delay", gate, 3'b001);
        at_us(t0, 17); chk("R4 zero delay held", gate, 3'b001);
        at_us(t0, 23); chk("R4 zero delay end", gate, 3'b000);
    endtask

    task automatic t_clamp();
        longint t0;
        repeat (420 * CPU) @(negedge clk);
        send_sp(4'd0);
        zc_hit(1, t0);
        at_us(t0, 92); chk("R7 clamp early", gate, 3'b000);
        at_us(t0, 98); chk("R7 clamp fire", gate, 3'b010);
        at_us(t0, 130);
    endtask

    task automatic t_restart();
        longint t0, t1;
        repeat (420 * CPU) @(negedge clk);
        send_sp(4'd10);
        zc_hit(0, t0);
        at_us(t0, 30);
        zc_hit(0, t1);
        at_us(t0, 53); chk("R9 no fire at old time", gate, 3'b000);
        at_us(t0, 77); chk("R9 restart early", gate, 3'b000);
        at_us(t0, 83); chk("R9 restart fire", gate, 3'b001);
        at_us(t0, 110);
    endtask

    task automatic t_rearm();
        longint t0, t1;
        zc_hit(1, t0);
        at_us(t0, 53); chk("R10 first fire", gate, 3'b010);
        at_us(t0, 60);
        zc_hit(1, t1);
        at_us(t0, 67);  chk("R10 pulse not cut", gate, 3'b010);
        at_us(t0, 73);  chk("R10 pulse end", gate, 3'b000);
        at_us(t0, 107); chk("R10 rearm early", gate, 3'b000);
        at_us(t0, 113); chk("R10 rearm fire", gate, 3'b010);
        at_us(t0, 135); chk("R10 second end", gate, 3'b000);
    endtask

    task automatic t_indep();
        longint t0, t1;
        zc_hit(0, t0);
        at_us(t0, 20); zc_hit(1, t1);
        at_us(t0, 40); zc_hit(2, t1);
        at_us(t0, 53);  chk("R11 ch0", gate, 3'b001);
        at_us(t0, 75);  chk("R11 ch1", gate, 3'b010);
        at_us(t0, 95);  chk("R11 ch2", gate, 3'b100);
        at_us(t0, 115); chk("R11 all done", gate, 3'b000);
    endtask

    task automatic t_level();
        longint t0;
        t0 = cyc;
        zc_n[2] = 1'b0;
        at_us(t0, 53); chk("R1 fall starts timing", gate, 3'b100);
        at_us(t0, 60);
        zc_n[2] = 1'b1;
        at_us(t0, 73); chk("R1 low level no refire", gate, 3'b000);
        quiet("R1 rising edge ignored", t0, 75, 200);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_default();
                t_scale();
                t_clamp();
                t_restart();
                t_rearm();
                t_indep();
                t_level();
            end
            begin
                repeat (150000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog: run did not finish, expected end before 150000 cycles");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule